// File: doc/BRIEF.md
# Sync Word and Coarse Offset Tracker

This block follows a chirp receiver once a preamble has been detected. For every block of received samples it takes two peak bin indices. One comes from the path that multiplies by the conjugate base chirp (up bin). The other comes from the path that multiplies by the plain base chirp (down bin). A state machine advances once per block strobe. It takes the first up bin as the reference and counts preamble blocks against a programmed limit. It then looks for two sync symbols sitting a programmed distance above the reference, and one bin of error is allowed on each comparison. It skips one block and takes the down bin of the following block.

From the reference up bin and that down bin, the block works out the integer carrier offset as a signed bin count and the integer timing offset in samples. When it finishes it reports either a found status with both offsets or a rejected status. Both statuses are held until the next start pulse.

Top module: `sync_tracker`

## Requirements
- R1: After reset, `found` and `rejected` are 0 and `sto_o` and `cfo_o` are 0.
- R2: A `start` pulse clears both statuses and arms the tracker. The first block strobe after it stores `up_bin` as the reference. When `start` and `blk_valid` arrive in the same cycle, `start` wins and the block is not used.
- R3: A block whose up bin is within ±1 of the reference counts as a preamble block, and the reference block itself counts as one. If such a block arrives when `pre_len` blocks have already been counted, the tracker raises `rejected` at that strobe. Up to `pre_len` preamble blocks are accepted.
- R4: A block whose up bin is within ±1 (modulo N) of reference + `sync_val` is a sync symbol. This test has priority over the preamble test. After the first sync symbol, the next block must also match, or `rejected` rises.
- R5: In the preamble phase, a block that matches neither the reference nor the sync target raises `rejected`.
- R6: After the second sync symbol, one block is ignored. `found` rises at the clock edge that samples the block after it, and the `dn_bin` of that block is used.
- R7: The sum (f_up + f_down) is taken without wrap and then halved with the remainder dropped. The result modulo N/2 is mapped into [−N/4, N/4) and driven as the two's complement `cfo_o`.
- R8: `sto_o` equals (`cfo_o` − f_up) modulo N, where f_up is the reference bin.
- R9: While `found` or `rejected` is high, block strobes have no effect. The status and both offsets hold until `start`.
- R10: All ±1 comparisons wrap modulo N, so bins N−1 and 0 are neighbours.
- R11: With `sync_val` = 0, the second block after arming already counts as the first sync symbol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Arms the tracker and clears the statuses |
| blk_valid | input | 1 | One-cycle strobe per block of samples |
| up_bin | input | LOGN | Peak bin from the conjugate-chirp path |
| dn_bin | input | LOGN | Peak bin from the plain-chirp path |
| sync_val | input | LOGN | Programmed sync symbol value |
| pre_len | input | CNTW | Maximum number of preamble blocks |
| found | output | 1 | Sync word found, offsets valid |
| rejected | output | 1 | Frame rejected |
| sto_o | output | LOGN | Integer timing offset, 0..N−1 |
| cfo_o | output | LOGN | Integer carrier offset in bins, signed |

## Verification
Each result is one register stage behind the strobe that decides it. `found`, `rejected` and both offsets change at the rising edge that samples the deciding block. The bench drives each block on a falling edge and removes it on the next falling edge. It reads the outputs on that second falling edge, so every check falls exactly one edge after its block. Where a status must not yet have risen, the bench reads it after the block just before the deciding one. The expected offsets come from a chosen timing and carrier offset, which the bench turns into the two bins it sends.

// File: rtl/sync_tracker.sv
module sync_tracker #(
  parameter int LOGN = 7,
  parameter int CNTW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            blk_valid,
  input  logic [LOGN-1:0] up_bin,
  input  logic [LOGN-1:0] dn_bin,
  input  logic [LOGN-1:0] sync_val,
  input  logic [CNTW-1:0] pre_len,
  output logic            found,
  output logic            rejected,
  output logic [LOGN-1:0] sto_o,
  output logic [LOGN-1:0] cfo_o
);
  localparam int N   = 1 << LOGN;
  localparam int QTR = N / 4;

  typedef enum logic [2:0] {ST_IDLE, ST_PRE, ST_SW2, ST_DN1, ST_DN2, ST_DONE, ST_REJ} st_t;

  st_t             st_q;
  logic [LOGN-1:0] ref_q;
  logic [CNTW-1:0] cnt_q;

  function automatic logic near(input logic [LOGN-1:0] a, input logic [LOGN-1:0] b);
    logic [LOGN-1:0] d;
    d = a - b;
    return (d == '0) || (d == LOGN'(1)) || (d == '1);
  endfunction

  logic [LOGN-1:0] sw_tgt;
  logic [LOGN:0]   bin_sum;
  logic [LOGN-2:0] half_mod;
  logic [LOGN-1:0] cfo_n;
  logic [LOGN-1:0] sto_n;

  assign sw_tgt   = ref_q + sync_val;
  assign bin_sum  = {1'b0, ref_q} + {1'b0, dn_bin};
  assign half_mod = bin_sum[LOGN-1:1];
  assign cfo_n    = {half_mod[LOGN-2], half_mod};
  assign sto_n    = cfo_n - ref_q;

  assign found    = (st_q == ST_DONE);
  assign rejected = (st_q == ST_REJ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      ref_q <= '0;
      cnt_q <= '0;
      sto_o <= '0;
      cfo_o <= '0;
    end else if (start) begin
      st_q  <= ST_PRE;
      cnt_q <= '0;
    end else if (blk_valid) begin
      case (st_q)
        ST_PRE: begin
          if (cnt_q == '0) begin
            ref_q <= up_bin;
            cnt_q <= CNTW'(1);
          end else if (near(up_bin, sw_tgt)) begin
            st_q <= ST_SW2;
          end else if (near(up_bin, ref_q)) begin
            if (cnt_q >= pre_len) st_q <= ST_REJ;
            else                  cnt_q <= cnt_q + CNTW'(1);
          end else begin
            st_q <= ST_REJ;
          end
        end
        ST_SW2: st_q <= near(up_bin, sw_tgt) ? ST_DN1 : ST_REJ;
        ST_DN1: st_q <= ST_DN2;
        ST_DN2: begin
          st_q  <= ST_DONE;
          cfo_o <= cfo_n;
          sto_o <= sto_n;
        end
        default: st_q <= st_q;
      endcase
    end
  end

  p_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> ($signed(cfo_o) >= -QTR && $signed(cfo_o) < QTR));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((found || rejected) && !start) |=> ($stable(sto_o) && $stable(cfo_o) && $stable(found) && $stable(rejected)));

  p_found_on_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(found) |-> $past(blk_valid));

  p_reject_on_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rejected) |-> $past(blk_valid) && !$past(start));

  p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!found && !rejected));
endmodule

// File: tb/sync_tracker_tb_top.sv
module sync_tracker_tb_top;
  localparam int LOGN = 7;
  localparam int N = 1 << LOGN;

  logic clk = 0, rst_n = 0, start = 0, blk_valid = 0;
  logic [LOGN-1:0] up_bin = 0, dn_bin = 0, sync_val = 0;
  logic [15:0] pre_len = 0;
  logic found, rejected;
  logic [LOGN-1:0] sto_o, cfo_o;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  sync_tracker #(.LOGN(LOGN), .CNTW(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .blk_valid(blk_valid),
    .up_bin(up_bin), .dn_bin(dn_bin), .sync_val(sync_val), .pre_len(pre_len),
    .found(found), .rejected(rejected), .sto_o(sto_o), .cfo_o(cfo_o));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic arm(input int x, input int plen);
    @(negedge clk);
    sync_val = LOGN'(x); pre_len = 16'(plen); start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic blk(input int u, input int d);
    @(negedge clk);
    up_bin = LOGN'(u); dn_bin = LOGN'(d); blk_valid = 1;
    @(negedge clk);
    blk_valid = 0;
  endtask

  function automatic int md(input int v);
    return ((v % N) + N) % N;
  endfunction

  task automatic t_frame(input string tag, input int sto, input int cfo, input int x);
    int fu, fd;
    fu = md(cfo - sto); fd = md(cfo + sto);
    arm(x, 4);
    blk(fu, 0); blk(fu, 0); blk(fu, 0);
    blk(md(fu + x), 0); blk(md(fu + x), 0);
    blk(fu, 3);
    chk({tag, " R6 not yet"}, found, 0);
    blk(0, fd);
    chk({tag, " R6 found"}, found, 1);
    chk({tag, " R7 cfo"}, $signed(cfo_o), cfo);
    chk({tag, " R8 sto"}, sto_o, sto);
  endtask

  task automatic t_reset;
    chk("R1 found", found, 0);
    chk("R1 rejected", rejected, 0);
    chk("R1 sto", sto_o, 0);
    chk("R1 cfo", cfo_o, 0);
  endtask

  task automatic t_wrap;
    arm(5, 4);
    blk(127, 0); blk(0, 0); blk(126, 0);
    chk("R10 no reject", rejected, 0);
    blk(4, 0); blk(3, 0); blk(127, 0); blk(0, 89);
    chk("R10 found", found, 1);
    chk("R7 neg cfo", $signed(cfo_o), -20);
    chk("R8 sto wrap", sto_o, 109);
  endtask

  task automatic t_long;
    arm(20, 3);
    blk(50, 0); blk(51, 0); blk(49, 0);
    chk("R3 limit ok", rejected, 0);
    blk(50, 0);
    chk("R3 overlong", rejected, 1);
  endtask

  task automatic t_sync_miss;
    arm(20, 4);
    blk(50, 0); blk(70, 0); blk(80, 0);
    chk("R4 second sync miss", rejected, 1);
  endtask

  task automatic t_stray;
    arm(20, 4);
    blk(50, 0); blk(60, 0);
    chk("R5 stray block", rejected, 1);
  endtask

  task automatic t_hold;
    t_frame("hold", 12, 7, 9);
    blk(3, 90); blk(4, 11);
    chk("R9 found held", found, 1);
    chk("R9 cfo held", $signed(cfo_o), 7);
    chk("R9 sto held", sto_o, 12);
    @(negedge clk); start = 1; blk_valid = 1; up_bin = 77;
    @(negedge clk); start = 0; blk_valid = 0;
    chk("R2 start clears", found, 0);
    blk(33, 0); blk(34, 0);
    chk("R2 ref from first block", rejected, 0);
  endtask

  task automatic t_zero;
    int fu;
    fu = md(3 - 40);
    arm(0, 4);
    blk(fu, 0); blk(fu, 0); blk(fu, 0); blk(fu, 0);
    blk(0, md(3 + 40));
    chk("R11 zero sync found", found, 1);
    chk("R11 cfo", $signed(cfo_o), 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_frame("basic", 37, 10, 8);
    t_wrap;
    t_long;
    t_sync_miss;
    t_stray;
    t_hold;
    t_zero;
    t_frame("edge lo", 0, -32, 8);
    t_frame("edge hi", 0, 31, 8);
    t_frame("odd", 55, -7, 100);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule